// File: doc/BRIEF.md
# Program Counter Branch Loader

This block keeps the instruction fetch address of a small 12-bit-word controller and works out the following address once per instruction cycle. A one-hot-free, 3-bit instruction class coming from the decoder decides the update. An ordinary instruction advances the address by one. A long jump takes its nine low bits from the instruction's immediate field. A subroutine call takes eight low bits from the immediate field. A computed jump, meaning any instruction whose destination is the low byte of the counter, takes eight low bits from the ALU result. A return loads the whole address handed over by the return stack.

For calls and computed jumps, bit 8 is always forced to zero. Subroutine entry points and jump tables therefore have to sit in the lower half of a 512-word page, while a long jump can reach anywhere in the page. When the counter is wider than nine bits, the page preselect inputs supply the bits above bit 8 for all three kinds of load.

The incremented address is presented combinationally, so that the stack can push it on a call. Reset places the counter at the last word of the address space. With the page preselect cleared, a long jump stored there lands in page 0.

Top module: `pcl_branch_loader`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes all ones, and this holds whatever `step_en` and `br_kind` are.
- R2: With `rst` low and `step_en` low, `pc_q` keeps its value across the edge for every `br_kind`.
- R3: With `step_en` high and `br_kind` = 0 (sequential), `pc_q` becomes `pc_q`+1 modulo 2^PC_W. All ones wraps to zero.
- R4: With `br_kind` = 1 (long jump), `pc_q[8:0]` becomes `imm_addr[8:0]` and the bits above 8 become `page_sel`.
- R5: With `br_kind` = 2 (call), `pc_q[7:0]` becomes `imm_addr[7:0]` and `pc_q[8]` becomes 0 even when `imm_addr[8]` is 1. The bits above 8 become `page_sel`.
- R6: With `br_kind` = 3 (write to the low counter byte), `pc_q[7:0]` becomes `alu_res`, `pc_q[8]` becomes 0, and the bits above 8 become `page_sel`.
- R7: With `br_kind` = 4 (return), `pc_q` becomes `ret_addr` over its full width, and `page_sel` has no effect.
- R8: `pc_inc` always equals `pc_q`+1 modulo 2^PC_W, in the same cycle.
- R9: The unused codes 5, 6 and 7 of `br_kind` behave exactly like sequential. `page_sel`, `imm_addr` and `alu_res` have no effect on sequential steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Instruction cycle enable |
| br_kind | input | 3 | Instruction class: 0 seq, 1 jump, 2 call, 3 low-byte write, 4 return |
| imm_addr | input | 9 | Immediate address field of the instruction |
| alu_res | input | 8 | ALU result for low-byte writes |
| page_sel | input | SEL_W (max(1, PC_W-9)) | Page preselect bits for bits above 8 |
| ret_addr | input | PC_W | Return address from the stack |
| pc_q | output | PC_W | Current fetch address |
| pc_inc | output | PC_W | Fetch address plus one (call push value) |

## Verification
A wrong counter value shows up at `pc_q` on the edge that follows the faulty update, and at `pc_inc` in that same cycle. Every step is therefore compared against a model one cycle after it is issued. A mistake in forcing bit 8 only appears when an immediate or page value has that bit set, so the stimulus deliberately sets `imm_addr[8]` high on calls. A stuck page path only appears with nonzero preselect values, which is why the bench uses an 11-bit counter. An error in the wrap from all ones to zero appears right after reset, on the first sequential step.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int LOW_W  = 9;
    localparam int OFFS_W = 8;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        BR_SEQ  = 3'd0,
        BR_JUMP = 3'd1,
        BR_CALL = 3'd2,
        BR_PCW  = 3'd3,
        BR_RET  = 3'd4
    } br_kind_e;

    function automatic int sel_width(input int pc_w);
        return (pc_w > LOW_W) ? pc_w - LOW_W : 1;
    endfunction

endpackage

// File: rtl/pcl_incr.sv
module pcl_incr #(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    assign y = a + W'(1);
endmodule

// File: rtl/pcl_next_sel.sv
module pcl_next_sel
    import pcl_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int SEL_W = 1
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [PC_W-1:0]   cur_inc,
    input  logic [LOW_W-1:0]  imm,
    input  logic [OFFS_W-1:0] alu,
    input  logic [SEL_W-1:0]  page,
    input  logic [PC_W-1:0]   ret,
    output logic [PC_W-1:0]   nxt
);
    logic [LOW_W-1:0] far_low;
    logic [PC_W-1:0]  far_pc;

    // Low nine bits of a loaded target; bit 8 only survives on long jumps.
    always_comb begin
        case (kind)
            BR_JUMP: far_low = imm;
            BR_CALL: far_low = {1'b0, imm[OFFS_W-1:0]};
            default: far_low = {1'b0, alu};
        endcase
    end

    generate
        if (PC_W > LOW_W) begin : g_paged
            assign far_pc = {page, far_low};
        end else begin : g_flat
            logic unused_page;
            assign unused_page = ^page;
            assign far_pc = far_low[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        case (kind)
            BR_JUMP, BR_CALL, BR_PCW: nxt = far_pc;
            BR_RET:                   nxt = ret;
            default:                  nxt = cur_inc;
        endcase
    end
endmodule

// File: rtl/pcl_reg.sv
module pcl_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pcl_branch_loader.sv
module pcl_branch_loader
    import pcl_pkg::*;
#(
    parameter  int PC_W  = 9,
    localparam int SEL_W = sel_width(PC_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [KIND_W-1:0] br_kind,
    input  logic [LOW_W-1:0]  imm_addr,
    input  logic [OFFS_W-1:0] alu_res,
    input  logic [SEL_W-1:0]  page_sel,
    input  logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   pc_q,
    output logic [PC_W-1:0]   pc_inc
);
    logic [PC_W-1:0] pc_next;

    pcl_incr #(.W(PC_W)) u_incr (
        .a (pc_q),
        .y (pc_inc)
    );

    pcl_next_sel #(.PC_W(PC_W), .SEL_W(SEL_W)) u_sel (
        .kind    (br_kind),
        .cur_inc (pc_inc),
        .imm     (imm_addr),
        .alu     (alu_res),
        .page    (page_sel),
        .ret     (ret_addr),
        .nxt     (pc_next)
    );

    pcl_reg #(.W(PC_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (step_en),
        .d   (pc_next),
        .q   (pc_q)
    );
endmodule

// File: rtl/pcl_branch_loader_chk.sv
module pcl_branch_loader_chk
    import pcl_pkg::*;
#(
    parameter int PC_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic [KIND_W-1:0] br_kind,
    input logic [LOW_W-1:0]  imm_addr,
    input logic [PC_W-1:0]   ret_addr,
    input logic [PC_W-1:0]   pc_q,
    input logic [PC_W-1:0]   pc_inc
);
    p_reset_vec_r1: assert property (@(posedge clk) rst |=> (pc_q == '1));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pc_q));

    p_seq_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && br_kind == BR_SEQ) |=> (pc_q == $past(pc_inc)));

    p_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && br_kind == BR_JUMP) |=> (pc_q[LOW_W-1:0] == $past(imm_addr)));

    p_call_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && br_kind == BR_CALL) |=>
        (pc_q[OFFS_W] == 1'b0 && pc_q[OFFS_W-1:0] == $past(imm_addr[OFFS_W-1:0])));

    p_pcw_r6: assert property (@(posedge clk) disable iff (rst)
        (step_en && br_kind == BR_PCW) |=> (pc_q[OFFS_W] == 1'b0));

    p_ret_r7: assert property (@(posedge clk) disable iff (rst)
        (step_en && br_kind == BR_RET) |=> (pc_q == $past(ret_addr)));

    p_inc_r8: assert property (@(posedge clk) disable iff (rst)
        (pc_inc - pc_q) == PC_W'(1));

    p_spare_r9: assert property (@(posedge clk) disable iff (rst)
        (step_en && br_kind > BR_RET) |=> (pc_q == $past(pc_q) + PC_W'(1)));
endmodule

bind pcl_branch_loader pcl_branch_loader_chk #(.PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .br_kind  (br_kind),
    .imm_addr (imm_addr),
    .ret_addr (ret_addr),
    .pc_q     (pc_q),
    .pc_inc   (pc_inc)
);

// File: tb/sim_pcl_branch_loader.sv
`timescale 1ns/1ps
module sim_pcl_branch_loader;
    localparam int W = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step_en = 1'b0;
    logic [2:0]    br_kind = 3'd0;
    logic [8:0]    imm_addr = '0;
    logic [7:0]    alu_res = '0;
    logic [1:0]    page_sel = '0;
    logic [W-1:0]  ret_addr = '0;
    logic [W-1:0]  pc_q;
    logic [W-1:0]  pc_inc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [W-1:0] model;

    always #2 clk = ~clk;

    pcl_branch_loader #(.PC_W(W)) u0 (
        .clk(clk), .rst(rst), .step_en(step_en), .br_kind(br_kind),
        .imm_addr(imm_addr), .alu_res(alu_res), .page_sel(page_sel),
        .ret_addr(ret_addr), .pc_q(pc_q), .pc_inc(pc_inc)
    );

    function automatic logic [W-1:0] ref_next(input logic [2:0] k, input logic [W-1:0] pc,
        input logic [8:0] im, input logic [7:0] al, input logic [1:0] pg, input logic [W-1:0] rt);
        case (k)
            3'd1: return {pg, im};
            3'd2: return {pg, 1'b0, im[7:0]};
            3'd3: return {pg, 1'b0, al};
            3'd4: return rt;
            default: return pc + 11'd1;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // one cycle: inputs set away from the edge, pc_q compared after the edge
    task automatic step(input string req, input logic en, input logic [2:0] k,
        input logic [8:0] im, input logic [7:0] al, input logic [1:0] pg, input logic [W-1:0] rt);
        @(negedge clk);
        step_en = en; br_kind = k; imm_addr = im; alu_res = al; page_sel = pg; ret_addr = rt;
        #0.5;
        check("R8", pc_inc, model + 11'd1);
        if (en) model = ref_next(k, model, im, al, pg, rt);
        @(posedge clk);
        #1;
        check(req, pc_q, model);
    endtask

    task automatic do_reset(input logic en, input logic [2:0] k);
        @(negedge clk);
        rst = 1'b1; step_en = en; br_kind = k;
        @(posedge clk);
        #1;
        model = '1;
        check("R1", pc_q, 11'h7FF);
        @(negedge clk);
        rst = 1'b0; step_en = 1'b0;
    endtask

    initial begin
        #(4.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250));
        model = '1;
        do_reset(1'b0, 3'd0);
        // R3: wrap from the reset vector
        step("R3", 1'b1, 3'd0, 9'h1FF, 8'hFF, 2'd3, 11'h123);
        check("R3", pc_q, 11'h000);
        // reset vector then long jump with page 0
        do_reset(1'b1, 3'd2);
        step("R4", 1'b1, 3'd1, 9'h1A5, 8'h00, 2'd0, '0);
        check("R4", pc_q, 11'h1A5);
        step("R5", 1'b1, 3'd2, 9'h1C3, 8'h00, 2'd2, '0);
        check("R5", pc_q, 11'h4C3);
        step("R6", 1'b1, 3'd3, 9'h1FF, 8'h9E, 2'd3, '0);
        check("R6", pc_q, 11'h69E);
        step("R7", 1'b1, 3'd4, 9'h1FF, 8'hFF, 2'd1, 11'h5F0);
        check("R7", pc_q, 11'h5F0);
        step("R2", 1'b0, 3'd1, 9'h000, 8'h00, 2'd0, '0);
        step("R2", 1'b0, 3'd4, 9'h000, 8'h00, 2'd0, '0);
        check("R2", pc_q, 11'h5F0);
        for (int c = 5; c < 8; c++) step("R9", 1'b1, 3'(c), 9'h0AA, 8'h55, 2'd3, 11'h000);
        check("R9", pc_q, 11'h5F3);
        step("R9", 1'b1, 3'd0, 9'h1FF, 8'hFF, 2'd2, 11'h7FF);
        do_reset(1'b1, 3'd4);
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] k;
            k = 3'($urandom_range(0, 7));
            step(k == 3'd0 ? "R3" : k == 3'd1 ? "R4" : k == 3'd2 ? "R5" :
                 k == 3'd3 ? "R6" : k == 3'd4 ? "R7" : "R9",
                 ($urandom_range(0, 4) != 0), k, 9'($urandom), 8'($urandom),
                 2'($urandom), 11'($urandom));
            if (i % 500 == 499) do_reset(1'($urandom), k);
        end
        finish_run();
    end
endmodule